// File: doc/BRIEF.md
# Decade Divider with Staged PPS Retiming

This block turns a 10 MHz reference into a once-per-second pulse by counting through a chain of divide-by-ten stages. The first stage is split into a divide-by-five part followed by a divide-by-two part. The divide-by-five part marks a 2 MHz point, and its carry into the divide-by-two part marks a 1 MHz point. The block also drives a 5 MHz square wave and a 1 MHz square wave. A synchronisation input clears every stage at the same moment, so the pulse phase can be lined up with an outside event.

The terminal flag of the chain is not sent to the output directly. It passes through three retiming steps. It is registered first at the 1 MHz point, then at the 2 MHz point, and last on the reference clock edge. Each step only has to absorb the delay of the stages below it. The pulse edge therefore keeps a fixed offset from a reference edge.

The whole design runs in one clock domain. The 1 MHz and 2 MHz points are single-cycle enables decoded from the first-stage count, not separate clocks. The parameter `N_DECADES` sets the number of decade stages, including the first one. With the default of 7, a 10 MHz clock gives one pulse per second.

Top module: `ddiv_pps_top`

## Requirements
- R1: In the cycle after a clock edge that samples `sync_i` high, `pps_o`, `tap5m_o` and `tap1m_o` are all 0. Call that cycle n=0; cycles after it are n=1, 2, and so on.
- R2: After release, `tap5m_o` toggles every cycle. It is 1 in odd cycles and 0 in even cycles.
- R3: After release, `tap1m_o` has a period of 10 cycles, high for 5 and low for 5. For n>=1 it equals 1 exactly when ((n-1) mod 10) >= 5, so its first rising edge is at n=6.
- R4: The first rising edge of `pps_o` after release is at n=16. This is 10 cycles to the 1 MHz capture, 5 to the 2 MHz capture and 1 to the clock-edge register. `pps_o` stays 0 before that cycle.
- R5: Successive rising edges of `pps_o` are exactly 10^N_DECADES cycles apart.
- R6: Each pulse on `pps_o` stays high for exactly `PULSE_CYCLES` cycles.
- R7: Every rising edge of `pps_o` falls in the same cycle as a rising edge of `tap1m_o`.
- R8: Raising `sync_i` while a pulse is high ends the pulse in the next cycle. The sequence then restarts, with the first rising edge at n=16 after the new release.
- R9: The synchronous reset `rst` has the same effect as `sync_i` (R1, R4).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 10 MHz reference clock (nominal) |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Synchronous chain clear used for phase alignment |
| pps_o | output | 1 | Retimed pulse, one per 10^N_DECADES cycles |
| tap5m_o | output | 1 | Half-rate square wave |
| tap1m_o | output | 1 | Tenth-rate square wave |

## Verification
The bench uses a reduced chain of three decades, which gives a 1000-cycle period, and checks the chain after three different starts. The first start is from reset. The second is a sync raised in the middle of a pulse, which must truncate the pulse and restart the same latency. The third is a reset raised while the output is low, which tells a true restart apart from a plain masking of the output. Several back-to-back periods after the first start show whether the interval is exact and whether each rise falls on a tap edge. The cycle-by-cycle tap patterns just after release separate a correct biquinary phase from a shifted one.

// File: rtl/ddiv_pkg.sv
package ddiv_pkg;
  localparam int DIGIT_W = 4;
  localparam int QUIN_W  = 3;
  localparam int QUIN_LAST = 4;
  localparam int DIGIT_LAST = 9;

  typedef logic [DIGIT_W-1:0] digit_t;
  typedef logic [QUIN_W-1:0]  quin_t;

  typedef struct packed {
    logic en2m;
    logic en1m;
  } strobe_t;

  function automatic longint unsigned pow10(input int n);
    longint unsigned v;
    v = 1;
    for (int i = 0; i < n; i++) v = v * 10;
    return v;
  endfunction
endpackage

// File: rtl/ddiv_prescaler.sv
module ddiv_prescaler
  import ddiv_pkg::*;
(
  input  logic    clk,
  input  logic    clear,
  output strobe_t stb,
  output logic    tap5m_q,
  output logic    tap1m_q
);
  quin_t quin;
  logic  half;

  always_ff @(posedge clk) begin
    if (clear) begin
      quin    <= '0;
      half    <= 1'b0;
      tap5m_q <= 1'b0;
      tap1m_q <= 1'b0;
    end else begin
      quin    <= (quin == quin_t'(QUIN_LAST)) ? '0 : quin + quin_t'(1);
      if (quin == quin_t'(QUIN_LAST)) half <= ~half;
      tap5m_q <= ~tap5m_q;
      tap1m_q <= half;
    end
  end

  assign stb.en2m = (quin == quin_t'(QUIN_LAST));
  assign stb.en1m = (quin == quin_t'(QUIN_LAST)) && half;
endmodule

// File: rtl/ddiv_decade_chain.sv
module ddiv_decade_chain
  import ddiv_pkg::*;
#(
  parameter int N_UPPER = 6
)(
  input  logic clk,
  input  logic clear,
  input  logic en_in,
  output logic raw_q
);
  digit_t             digit [N_UPPER];
  logic [N_UPPER-1:0] carry;
  logic [N_UPPER-1:0] is_zero;

  assign carry[0] = en_in;

  for (genvar g = 0; g < N_UPPER; g++) begin : g_dec
    always_ff @(posedge clk) begin
      if (clear) digit[g] <= '0;
      else if (carry[g])
        digit[g] <= (digit[g] == digit_t'(DIGIT_LAST)) ? '0 : digit[g] + digit_t'(1);
    end
    assign is_zero[g] = (digit[g] == '0);
    if (g + 1 < N_UPPER) begin : g_carry
      assign carry[g+1] = carry[g] && (digit[g] == digit_t'(DIGIT_LAST));
    end
  end

  // Raw terminal flag: high for one tenth-rate period after each wrap.
  always_ff @(posedge clk) begin
    if (clear) raw_q <= 1'b0;
    else       raw_q <= &is_zero;
  end
endmodule

// File: rtl/ddiv_retime.sv
module ddiv_retime
  import ddiv_pkg::*;
#(
  parameter int PULSE_CYCLES = 1000
)(
  input  logic    clk,
  input  logic    clear,
  input  strobe_t stb,
  input  logic    raw_i,
  output logic    pps_q
);
  localparam int CNT_W = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;

  logic             at1m, at2m, at2m_prev;
  logic [CNT_W-1:0] hold;

  always_ff @(posedge clk) begin
    if (clear) begin
      at1m      <= 1'b0;
      at2m      <= 1'b0;
      at2m_prev <= 1'b0;
      pps_q     <= 1'b0;
      hold      <= '0;
    end else begin
      if (stb.en1m) at1m <= raw_i;
      if (stb.en2m) at2m <= at1m;
      at2m_prev <= at2m;
      if (at2m && !at2m_prev) begin
        pps_q <= 1'b1;
        hold  <= CNT_W'(PULSE_CYCLES - 1);
      end else if (hold != '0) begin
        hold  <= hold - CNT_W'(1);
      end else begin
        pps_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/ddiv_pps_top.sv
module ddiv_pps_top
  import ddiv_pkg::*;
#(
  parameter int N_DECADES    = 7,
  parameter int PULSE_CYCLES = 1000
)(
  input  logic clk,
  input  logic rst,
  input  logic sync_i,
  output logic pps_o,
  output logic tap5m_o,
  output logic tap1m_o
);
  localparam int N_UPPER = N_DECADES - 1;

  logic    clear;
  strobe_t stb;
  logic    raw;

  assign clear = rst | sync_i;

  ddiv_prescaler u_pre (
    .clk     (clk),
    .clear   (clear),
    .stb     (stb),
    .tap5m_q (tap5m_o),
    .tap1m_q (tap1m_o)
  );

  ddiv_decade_chain #(.N_UPPER(N_UPPER)) u_chain (
    .clk   (clk),
    .clear (clear),
    .en_in (stb.en1m),
    .raw_q (raw)
  );

  ddiv_retime #(.PULSE_CYCLES(PULSE_CYCLES)) u_rt (
    .clk   (clk),
    .clear (clear),
    .stb   (stb),
    .raw_i (raw),
    .pps_q (pps_o)
  );
endmodule

// File: rtl/ddiv_pps_chk.sv
module ddiv_pps_chk
  import ddiv_pkg::*;
#(
  parameter int N_DECADES    = 7,
  parameter int PULSE_CYCLES = 1000
)(
  input logic clk,
  input logic rst,
  input logic sync_i,
  input logic pps_o,
  input logic tap5m_o,
  input logic tap1m_o
);
  localparam longint unsigned PERIOD = pow10(N_DECADES);
  // 10 cycles to the 1 MHz capture, 5 to the 2 MHz capture, 1 to the output register
  localparam longint unsigned FIRST_RISE = 16;

  logic            settled, pps_prev, seen;
  longint unsigned since, icnt, wcnt;

  always_ff @(posedge clk) begin
    settled <= !(rst || sync_i);
    if (rst || sync_i) begin
      pps_prev <= 1'b0;
      seen     <= 1'b0;
      since    <= 0;
      icnt     <= 0;
      wcnt     <= 0;
    end else begin
      pps_prev <= pps_o;
      since    <= since + 1;
      wcnt     <= pps_o ? wcnt + 1 : 0;
      if (pps_o && !pps_prev) begin
        seen <= 1'b1;
        icnt <= 1;
      end else begin
        icnt <= icnt + 1;
      end
    end
  end

  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (rst)
    sync_i |=> (!pps_o && !tap5m_o && !tap1m_o)); // R1

  AST_TAP5_TOGGLE: assert property (@(posedge clk) disable iff (rst || sync_i || !settled)
    tap5m_o != $past(tap5m_o)); // R2

  AST_FIRST_RISE: assert property (@(posedge clk) disable iff (rst || !settled)
    (pps_o && !pps_prev && !seen) |-> (since == FIRST_RISE)); // R4

  AST_PERIOD_EXACT: assert property (@(posedge clk) disable iff (rst || !settled)
    (pps_o && !pps_prev && seen) |-> (icnt == PERIOD)); // R5

  AST_PULSE_WIDTH: assert property (@(posedge clk) disable iff (rst || !settled)
    (!pps_o && pps_prev) |-> (wcnt == longint'(PULSE_CYCLES))); // R6

  AST_EDGE_ON_TAP: assert property (@(posedge clk) disable iff (rst || !settled)
    $rose(pps_o) |-> $rose(tap1m_o)); // R7
endmodule

bind ddiv_pps_top ddiv_pps_chk #(
  .N_DECADES    (N_DECADES),
  .PULSE_CYCLES (PULSE_CYCLES)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .sync_i  (sync_i),
  .pps_o   (pps_o),
  .tap5m_o (tap5m_o),
  .tap1m_o (tap1m_o)
);

// File: tb/sim_ddiv_pps_top.sv
module sim_ddiv_pps_top;
  localparam int N_DEC = 3;
  localparam int PW    = 100;
  localparam int PER   = 1000;
  localparam int LAT   = 16;

  typedef struct {
    longint at;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sync_i = 1'b0;
  logic pps_o, tap5m_o, tap1m_o;

  always #5 clk = ~clk;

  ddiv_pps_top #(.N_DECADES(N_DEC), .PULSE_CYCLES(PW)) u0 (
    .clk(clk), .rst(rst), .sync_i(sync_i),
    .pps_o(pps_o), .tap5m_o(tap5m_o), .tap1m_o(tap1m_o)
  );

  int     checks = 0;
  int     fails  = 0;
  longint cyc    = 0;
  longint base   = 0;
  exp_t   exp_q[$];
  exp_t   cur;
  bit     skip_w = 1'b0;
  bit     pp = 1'b0, tp = 1'b0;
  int     wcount = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++;
      $display("FAIL R5 watchdog actual=%0d expected=%0d", cyc, 20000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // Monitor: pops expected rise cycles and compares as the design produces them.
  always @(negedge clk) begin
    if (pps_o && !pp) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R5 unexpected rise", cyc, -1);
      end else begin
        cur = exp_q.pop_front();
        chk(cyc == cur.at, cur.tag, cyc, cur.at);
      end
      chk(tap1m_o && !tp, "R7", {tp, tap1m_o}, 2'b01);
    end
    if (pps_o) wcount++;
    if (!pps_o && pp) begin
      if (skip_w) skip_w = 1'b0;
      else chk(wcount == PW, "R6", wcount, PW);
      wcount = 0;
    end
    pp = pps_o;
    tp = tap1m_o;
  end

  // Driver: clears the chain and pushes the rise cycles it must produce.
  task automatic restart(input bit use_rst, input int periods, input string first_tag);
    @(negedge clk);
    skip_w = pps_o;
    if (use_rst) rst = 1'b1; else sync_i = 1'b1;
    exp_q.delete();
    @(negedge clk);
    chk({pps_o, tap5m_o, tap1m_o} == 3'b000, use_rst ? "R9" : "R1",
        {pps_o, tap5m_o, tap1m_o}, 0);
    rst = 1'b0;
    sync_i = 1'b0;
    base = cyc;
    for (int k = 0; k < periods; k++) begin
      exp_q.push_back('{at: base + LAT + longint'(k) * PER,
                        tag: (k == 0) ? first_tag : "R5"});
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    restart(1'b1, 4, "R4");
    for (int n = 1; n <= 30; n++) begin
      @(negedge clk);
      chk(tap5m_o == n[0], "R2", tap5m_o, n[0]);
      chk(tap1m_o == (((n - 1) % 10) >= 5), "R3", tap1m_o, ((n - 1) % 10) >= 5);
      chk(pps_o == (n >= LAT), "R4", pps_o, n >= LAT);
    end
    repeat (2100) @(negedge clk);
    @(posedge pps_o);
    repeat (40) @(negedge clk);
    chk(exp_q.size() == 0, "R5 missing rise", exp_q.size(), 0);
    // sync raised in the middle of the fourth pulse
    restart(1'b0, 2, "R8");
    chk(pps_o == 1'b0, "R8", pps_o, 0);
    repeat (1200) @(negedge clk);
    chk(exp_q.size() == 0, "R8 missing rise", exp_q.size(), 0);
    // reset raised while the output is low
    restart(1'b1, 1, "R9");
    repeat (100) @(negedge clk);
    chk(exp_q.size() == 0, "R9 missing rise", exp_q.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule